// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block moves a whole 256-byte page of CPU memory into the sprite memory of the video chip. The CPU starts it by writing a page number to the trigger input. On the next clock the engine halts the CPU and takes over the memory bus. It then alternates between reading one source byte and pushing that byte through the sprite data write port.

Sprite memory places each pushed byte at its own address pointer and then increments that pointer. The engine therefore never drives a destination address. The page lands starting at whatever offset the pointer already holds and wraps within 256. A nonzero pointer gives a rotated copy. When the last byte has gone out, the engine drops the halt and gives a one-clock completion pulse.

Top module: `sprite_page_dma`

## Requirements
- R1: After reset, `cpu_halt`, `bus_req`, `spr_we` and `done` are all low.
- R2: When the engine is idle, a `trig_we` pulse with page N raises `cpu_halt` on the next clock. On that same clock the first read is presented at address N*256, which is {N, 8'h00}.
- R3: The k-th read (k = 0..255) presents `bus_addr` = {N, k[7:0]}, with k taken in ascending order. The upper byte stays N for the whole transfer.
- R4: Every read cycle (`bus_req` high) is followed at once by a write cycle (`spr_we` high for one clock). That write carries the `bus_rdata` value sampled in the read cycle. `bus_req` and `spr_we` are never high together.
- R5: One trigger gives exactly 256 writes. `cpu_halt` stays high without a break for exactly 512 clocks.
- R6: `done` is high for exactly one clock, on the clock after the last write. `cpu_halt` is low on that same clock.
- R7: A `trig_we` pulse that is sampled while `cpu_halt` is high is ignored. This includes a pulse during the final write cycle. Such a pulse does not change the source page, the read order or the end time. No new transfer follows it.
- R8: A `trig_we` pulse sampled in the `done` clock is accepted, and a new transfer starts on the next clock as in R2.
- R9: The bytes are written in source order, so byte k of the page is the k-th write. A sprite memory whose pointer starts at S therefore holds source byte k at (S + k) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_we | input | 1 | CPU write strobe to the page trigger |
| trig_page | input | 8 | Source page number written by the CPU |
| cpu_halt | output | 1 | Holds the CPU stalled while a copy runs |
| bus_req | output | 1 | Memory read request (read cycle) |
| bus_addr | output | 16 | Memory read address |
| bus_rdata | input | 8 | Memory read data, valid in the request cycle |
| spr_we | output | 1 | Write strobe to the sprite data port |
| spr_wdata | output | 8 | Byte written to the sprite data port |
| done | output | 1 | One-clock pulse at the end of a copy |

## Verification
Two functions can meet in one clock: the end of a copy and the acceptance of a new trigger. The bench places a trigger in the final write cycle, where the copy must ignore it and then fall idle. It also places a trigger in the `done` clock, where a new copy at the new page must begin on the next clock. Random triggers at random points inside a running copy test R7, and a sprite memory model with a random start pointer judges where each byte lands.

// File: rtl/sprite_page_dma.sv
module sprite_page_dma #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_we,
  input  logic [ADDR_W-CNT_W-1:0] trig_page,
  output logic                    cpu_halt,
  output logic                    bus_req,
  output logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    spr_we,
  output logic [DATA_W-1:0]       spr_wdata,
  output logic                    done
);
  localparam int PAGE_W  = ADDR_W - CNT_W;
  localparam int XFER_CY = 2 * (2 ** CNT_W);

  logic              busy, wr_ph, done_q;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wr_ph  <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      page   <= '0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (trig_we) begin
          busy  <= 1'b1;
          page  <= trig_page;
          cnt   <= '0;
          wr_ph <= 1'b0;
        end
      end else if (!wr_ph) begin
        data_q <= bus_rdata;
        wr_ph  <= 1'b1;
      end else begin
        wr_ph <= 1'b0;
        cnt   <= cnt + 1'b1;
        if (cnt == '1) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cpu_halt  = busy;
  assign bus_req   = busy & ~wr_ph;
  assign bus_addr  = {page, cnt};
  assign spr_we    = busy & wr_ph;
  assign spr_wdata = data_q;
  assign done      = done_q;

  logic [CNT_W+1:0] chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n)         chk_len <= '0;
    else if (!cpu_halt) chk_len <= '0;
    else                chk_len <= chk_len + 1'b1;
  end

  // R2
  start_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && !cpu_halt) |=> (cpu_halt && bus_req && bus_addr[CNT_W-1:0] == '0));

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> (spr_we && spr_wdata == $past(bus_rdata)));

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && spr_we));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(spr_we)) |->
      (bus_addr[CNT_W-1:0] == $past(bus_addr[CNT_W-1:0], 2) + 1'b1 &&
       bus_addr[ADDR_W-1:CNT_W] == $past(bus_addr[ADDR_W-1:CNT_W], 2)));

  // R5
  halt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_len == XFER_CY[CNT_W+1:0]));

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cpu_halt && $past(spr_we)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_sprite_page_dma.sv
module tb_sprite_page_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_we = 1'b0;
  logic [7:0]  trig_page = 8'h00;
  logic        cpu_halt, bus_req, spr_we, done;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata, spr_wdata;
  logic [7:0]  salt = 8'h00;

  int checks = 0;
  int errors = 0;
  logic [7:0] sram [256];

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a, input logic [7:0] s);
    logic [7:0] lo, hi;
    lo = a[7:0] * 8'd29;
    hi = a[15:8] * 8'd113;
    return lo ^ hi ^ 8'h5A ^ s;
  endfunction

  assign bus_rdata = mem_fn(bus_addr, salt);

  sprite_page_dma dut (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_page(trig_page),
    .cpu_halt(cpu_halt), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .spr_we(spr_we), .spr_wdata(spr_wdata), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] pg, input logic [7:0] sstart, input int inj_at,
                      input logic [7:0] inj_pg, input bit already, input bit chain,
                      input logic [7:0] chain_pg);
    int bad_addr = 0, bad_data = 0, bad_halt = 0, writes = 0, bad_rot = 0;
    logic [7:0] sptr = sstart;
    if (!already) begin
      @(negedge clk);
      trig_we = 1'b1;
      trig_page = pg;
      @(negedge clk);
      trig_we = 1'b0;
    end
    chk(cpu_halt === 1'b1, "R2 halt on next clock", int'(cpu_halt), 1);
    chk(bus_req === 1'b1 && bus_addr === {pg, 8'h00}, "R2 first read address",
        int'(bus_addr), int'({pg, 8'h00}));
    for (int c = 0; c < 512; c++) begin
      if (cpu_halt !== 1'b1) bad_halt++;
      if (c % 2 == 0) begin
        if (!(bus_req === 1'b1 && spr_we === 1'b0 && bus_addr === {pg, 8'(c / 2)})) bad_addr++;
      end else begin
        if (!(spr_we === 1'b1 && bus_req === 1'b0)) bad_data++;
        else begin
          writes++;
          if (spr_wdata !== mem_fn({pg, 8'(c / 2)}, salt)) bad_data++;
          sram[sptr] = spr_wdata;
          sptr = sptr + 8'd1;
        end
      end
      trig_we = (c == inj_at);
      if (c == inj_at) trig_page = inj_pg;
      @(negedge clk);
    end
    trig_we = chain;
    if (chain) trig_page = chain_pg;
    chk(bad_addr == 0, "R3/R7 read address sequence", bad_addr, 0);
    chk(bad_data == 0, "R4 write follows read with read byte", bad_data, 0);
    chk(writes == 256 && bad_halt == 0, "R5 256 writes, 512 halt clocks", writes, 256);
    chk(done === 1'b1 && cpu_halt === 1'b0, "R6 done with halt low",
        int'({done, cpu_halt}), 2);
    for (int k = 0; k < 256; k++)
      if (sram[8'(int'(sstart) + k)] !== mem_fn({pg, 8'(k)}, salt)) bad_rot++;
    chk(bad_rot == 0, "R9 rotated placement", bad_rot, 0);
    @(negedge clk);
    trig_we = 1'b0;
    chk(done === 1'b0, "R6 done lasts one clock", int'(done), 0);
    if (chain)
      chk(cpu_halt === 1'b1 && bus_addr === {chain_pg, 8'h00}, "R8 trigger in done clock",
          int'(bus_addr), int'({chain_pg, 8'h00}));
    else
      chk(cpu_halt === 1'b0 && bus_req === 1'b0, "R7 no transfer after ignored trigger",
          int'(cpu_halt), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h1D5A;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(cpu_halt === 1'b0 && bus_req === 1'b0 && spr_we === 1'b0 && done === 1'b0,
        "R1 reset outputs", int'({cpu_halt, bus_req, spr_we, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_halt === 1'b0 && done === 1'b0, "R1 idle after reset", int'(cpu_halt), 0);

    xfer(8'h00, 8'h00, -1, 8'h00, 1'b0, 1'b0, 8'h00);
    salt = 8'h3C;
    xfer(8'hFF, 8'hC0, 511, 8'h12, 1'b0, 1'b0, 8'h00);
    salt = 8'h81;
    xfer(8'h02, 8'h01, 0, 8'h77, 1'b0, 1'b1, 8'h9A);
    xfer(8'h9A, 8'hFF, 1, 8'h44, 1'b1, 1'b0, 8'h00);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] pg = 8'($urandom);
      logic [7:0] ss = 8'($urandom);
      logic [7:0] ip = 8'($urandom);
      int at = ($urandom % 3 == 0) ? -1 : int'($urandom % 512);
      salt = 8'($urandom);
      repeat (1 + $urandom % 3) @(negedge clk);
      xfer(pg, ss, at, ip, 1'b0, 1'b0, 8'h00);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule